// File: doc/BRIEF.md
# Packed 16-bit multiply-accumulate unit

This datapath takes two 64-bit packed operands, a 64-bit accumulator and a 4-bit operation code. It returns one 64-bit result, registered, one clock after a request. The operands are treated as four 16-bit lanes at bit offsets 0, 16, 32 and 48, or as eight bytes for the byte difference sum. The unit can multiply lane by lane and keep either half of each product. It can also reduce the lane products in pairs or all together, sum absolute differences, or add products into the accumulator.

A request is a single cycle with `in_valid` high. All operations have the same one-cycle latency, so a new request can be issued every clock. Condition flags, saturation and register-file access are handled elsewhere. Operation codes 13 to 15 are reserved.

Top module: `pmac16_unit`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise. A synchronous active-high `rst` clears it.
- R2: In a cycle where `in_valid` is low, `out_data` keeps its previous value whatever the other inputs do.
- R3: Multiply-low (op 0 signed, op 1 unsigned) puts bits 15:0 of each lane product into the same lane. In signed mode the lanes are sign-extended before the multiply.
- R4: Multiply-high (op 2 signed, op 3 unsigned) puts bits 31:16 of each lane product into the same lane.
- R5: Pairwise multiply-add (op 4 signed, op 5 unsigned) writes lane0 product + lane1 product, truncated to 32 bits, into bits 31:0. It writes lane2 product + lane3 product, truncated the same way, into bits 63:32.
- R6: Four-way sum (op 6 signed, op 7 unsigned) returns the exact sum of all four lane products as a 64-bit value, sign-extended when signed.
- R7: Byte difference sum (op 8) returns the sum of |a−b| over the eight unsigned bytes. The result never exceeds 2040.
- R8: Halfword difference sum (op 9) returns the sum of |a−b| over the four unsigned 16-bit lanes.
- R9: Halfword accumulate adds signed lane products to `acc_in`, modulo 2^64. Op 10 adds the products of lanes 0 and 1; op 11 adds only the lane 0 product.
- R10: Word accumulate (op 12) adds the full signed product of bits 31:0 of `src_a` and bits 31:0 of `src_b` to `acc_in`, modulo 2^64.
- R11: Reserved ops 13 to 15 return zero, and `out_valid` is still asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand |
| acc_in | input | 64 | Accumulator input |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_data | output | 64 | Registered result |

## Verification
The hardest cases involve lanes holding 0x8000 or 0xFFFF. The signed product of two 0x8000 lanes is +2^30, and these lanes are where sign and zero extension give different answers. Lanes also carry into each other inside the pairwise and four-way reductions. Random operands almost never produce these values, so the stimulus builds operands lane by lane from a small pool of corner values (0, 1, 0x7FFF, 0x8000, 0xFFFF) mixed with random lanes. It runs every op code against this mix and against plain random data. Idle cycles with changing inputs and a reset during a request are also included.

// File: rtl/pmac16_unit.sv
module pmac16_unit #(
  parameter int LANES = 4,
  parameter int LW    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [LANES*LW-1:0] src_a,
  input  logic [LANES*LW-1:0] src_b,
  input  logic [LANES*LW-1:0] acc_in,
  output logic              out_valid,
  output logic [LANES*LW-1:0] out_data
);
  localparam int DW  = LANES * LW;
  localparam int PW  = 2 * LW + 2;
  localparam int NB  = DW / 8;
  localparam int HW  = DW / 2;

  logic sgn;
  assign sgn = (op < 4'd8) ? ~op[0] : 1'b1;

  logic [PW-1:0] prod   [LANES];
  logic [DW-1:0] prod_x [LANES];
  logic [LW-1:0] hdiff  [LANES];
  logic [7:0]    bdiff  [NB];
  logic [DW-1:0] lo_v, hi_v;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LW-1:0] la, lb;
    logic sa, sb;
    assign la = src_a[i*LW +: LW];
    assign lb = src_b[i*LW +: LW];
    assign sa = sgn & la[LW-1];
    assign sb = sgn & lb[LW-1];
    assign prod[i]   = $signed({{(LW+2){sa}}, la}) * $signed({{(LW+2){sb}}, lb});
    assign prod_x[i] = {{(DW-PW){prod[i][PW-1]}}, prod[i]};
    assign lo_v[i*LW +: LW] = prod[i][LW-1:0];
    assign hi_v[i*LW +: LW] = prod[i][2*LW-1:LW];
    assign hdiff[i] = (la > lb) ? la - lb : lb - la;
  end

  for (genvar j = 0; j < NB; j++) begin : g_byte
    assign bdiff[j] = (src_a[j*8 +: 8] > src_b[j*8 +: 8]) ?
                      src_a[j*8 +: 8] - src_b[j*8 +: 8] :
                      src_b[j*8 +: 8] - src_a[j*8 +: 8];
  end

  logic [DW-1:0] sum4, sad_b, sad_h, pair_v, word_p;
  always_comb begin
    sum4  = '0;
    sad_h = '0;
    sad_b = '0;
    for (int i = 0; i < LANES; i++) begin
      sum4  = sum4 + prod_x[i];
      sad_h = sad_h + {{(DW-LW){1'b0}}, hdiff[i]};
    end
    for (int j = 0; j < NB; j++)
      sad_b = sad_b + {{(DW-8){1'b0}}, bdiff[j]};
  end

  logic [HW-1:0] pair_lo, pair_hi;
  assign pair_lo = prod_x[0][HW-1:0] + prod_x[1][HW-1:0];
  assign pair_hi = prod_x[2][HW-1:0] + prod_x[3][HW-1:0];
  assign pair_v  = {pair_hi, pair_lo};
  assign word_p  = $signed({{HW{src_a[HW-1]}}, src_a[HW-1:0]}) *
                   $signed({{HW{src_b[HW-1]}}, src_b[HW-1:0]});

  logic [DW-1:0] res;
  always_comb begin
    case (op)
      4'd0, 4'd1: res = lo_v;
      4'd2, 4'd3: res = hi_v;
      4'd4, 4'd5: res = pair_v;
      4'd6, 4'd7: res = sum4;
      4'd8:       res = sad_b;
      4'd9:       res = sad_h;
      4'd10:      res = acc_in + prod_x[0] + prod_x[1];
      4'd11:      res = acc_in + prod_x[0];
      4'd12:      res = acc_in + word_p;
      default:    res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= res;
    end
  end
endmodule

// File: rtl/pmac16_unit_chk.sv
module pmac16_unit_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [3:0]    op,
  input logic          out_valid,
  input logic [DW-1:0] out_data
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> !out_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
  p_sad_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd8) |=> (out_data <= DW'(2040)));
  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 4'd13) |=> (out_valid && out_data == '0));
endmodule

bind pmac16_unit pmac16_unit_chk #(.DW(LANES*LW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
  .out_valid(out_valid), .out_data(out_data));

// File: tb/sim_pmac16_unit.sv
`timescale 1ns/1ps
module sim_pmac16_unit;
  logic clk = 0, rst = 1, in_valid = 0;
  logic [3:0] op = 0;
  logic [63:0] src_a = 0, src_b = 0, acc_in = 0;
  logic out_valid;
  logic [63:0] out_data;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [63:0] held = 0;

  always #2.5 clk = ~clk;

  pmac16_unit u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
    .out_valid(out_valid), .out_data(out_data));

  function automatic string req_of(input logic [3:0] o);
    case (o)
      0, 1: return "R3";
      2, 3: return "R4";
      4, 5: return "R5";
      6, 7: return "R6";
      8: return "R7";
      9: return "R8";
      10, 11: return "R9";
      12: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic longint lane(input logic [63:0] v, input int i, input bit s);
    logic [15:0] h = v[16*i +: 16];
    if (s) return longint'(signed'(h));
    return longint'({48'b0, h});
  endfunction

  function automatic logic [63:0] model(input logic [3:0] o, input logic [63:0] a, b, c);
    bit s = (o < 8) ? !o[0] : 1'b1;
    longint p [4];
    logic [63:0] r = 0;
    longint t;
    for (int i = 0; i < 4; i++) p[i] = lane(a, i, s) * lane(b, i, s);
    case (o)
      0, 1: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][15:0];
      2, 3: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][31:16];
      4, 5: begin t = p[0] + p[1]; r[31:0] = t[31:0]; t = p[2] + p[3]; r[63:32] = t[31:0]; end
      6, 7: r = p[0] + p[1] + p[2] + p[3];
      8: for (int j = 0; j < 8; j++) begin
           int x = int'(a[8*j +: 8]), y = int'(b[8*j +: 8]);
           r = r + ((x > y) ? x - y : y - x);
         end
      9: for (int i = 0; i < 4; i++) begin
           longint x = lane(a, i, 0), y = lane(b, i, 0);
           r = r + ((x > y) ? x - y : y - x);
         end
      10: r = c + p[0] + p[1];
      11: r = c + p[0];
      12: r = c + longint'(signed'(a[31:0])) * longint'(signed'(b[31:0]));
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [63:0] a, b, c);
    logic [63:0] e = model(o, a, b, c);
    @(negedge clk);
    in_valid = 1; op = o; src_a = a; src_b = b; acc_in = c;
    @(posedge clk); #1;
    check("R1", {63'b0, out_valid}, 64'd1);
    check(req_of(o), out_data, e);
    held = e;
  endtask

  task automatic idle(input logic [63:0] a);
    @(negedge clk);
    in_valid = 0; op = a[3:0]; src_a = a; src_b = ~a; acc_in = a ^ 64'h5A;
    @(posedge clk); #1;
    check("R1", {63'b0, out_valid}, 64'd0);
    check("R2", out_data, held);
  endtask

  function automatic logic [63:0] corner_word(input int k);
    logic [15:0] pool [5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
    logic [63:0] w;
    for (int i = 0; i < 4; i++) begin
      int sel = $urandom_range(0, 6);
      w[16*i +: 16] = (sel < 5) ? pool[(sel + k) % 5] : 16'($urandom);
    end
    return w;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", {63'b0, out_valid}, 64'd0);
    @(negedge clk); rst = 0;
    // directed corners for every op
    for (int o = 0; o < 16; o++) begin
      issue(4'(o), {4{16'h8000}}, {4{16'h8000}}, 64'h0123_4567_89AB_CDEF);
      issue(4'(o), {4{16'hFFFF}}, {4{16'hFFFF}}, 64'hFFFF_FFFF_FFFF_FFFF);
      issue(4'(o), {4{16'h8000}}, {4{16'hFFFF}}, 64'h8000_0000_0000_0000);
      issue(4'(o), 64'h00FF_00FF_00FF_00FF, 64'hFF00_FF00_FF00_FF00, 64'h0);
    end
    // R7 maximum byte difference sum
    issue(4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0);
    // R2 inputs change while idle
    for (int k = 0; k < 6; k++) idle({$urandom, $urandom});
    // mixed corner and random operands
    for (int n = 0; n < 600; n++) begin
      logic [3:0] o = 4'($urandom_range(0, 15));
      if (n % 2 == 0) issue(o, corner_word(n), corner_word(n + 2), {$urandom, $urandom});
      else issue(o, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
      if (n % 37 == 0) idle({$urandom, $urandom});
    end
    // R1 reset during a request clears valid
    @(negedge clk); in_valid = 1; op = 4'd0; rst = 1;
    @(posedge clk); #1;
    check("R1", {63'b0, out_valid}, 64'd0);
    @(negedge clk); rst = 0; in_valid = 0;
    issue(4'd12, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 64'd5);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule